// File: doc/BRIEF.md
# Payload Pointer Justification Generator

This block sits on the transmit side of a SONET-style framer that carries a payload running on its own clock. A small elastic FIFO absorbs the payload bytes; the block watches the FIFO fill level reported to it and decides once per frame whether the payload start can stay where it is. If the FIFO is running dry, the block performs a positive justification: one byte is left empty as stuff and the payload start moves one byte later. If the FIFO is filling up, it performs a negative justification: the third pointer byte carries payload and the payload start moves one byte earlier.

The block runs a byte-position counter over the frame, one byte per clock. From it, the block raises strobes for the three pointer bytes, for the stuff byte and for every byte that reads data from the FIFO. It also provides the 16-bit pointer word that a byte multiplexer places into the first two pointer bytes. In a justification frame the announced pointer is the old value with one interleaved group of its bits inverted. From the next frame on, the moved value is sent plainly. The justification thresholds are inputs driven from configuration registers elsewhere in the chip. A wrapping counter reports how many justifications have been made.

Top module: `ptr_just_gen`

## Requirements
- R1: While reset is held and in the first frame after it, the pointer word equals {4'b0110, 2'b00, PTR_INIT}, the justification count is 0, and no stuff or pointer-byte-data strobe is raised.
- R2: A frame lasts ROWS*COLS clocks. frame_start is high in the first byte (row 0, column 0). h1_en, h2_en and h3_en are high in columns 0, 1 and 2 of row PTR_ROW, each for one clock per frame.
- R3: The fill level is sampled in the last byte of each frame. If fill < thr_lo, the next frame is a positive justification. Otherwise, if fill > thr_hi, the next frame is a negative one. Otherwise, the next frame is normal. The positive case wins when both comparisons hold.
- R4: In a positive justification frame, pointer-word bits 9, 7, 5, 3 and 1 (mask 10'h2AA) are inverted against the current pointer. stuff_en is high in column 3 of row PTR_ROW, and payload_en is low in that byte.
- R5: In a negative justification frame, pointer-word bits 8, 6, 4, 2 and 0 (mask 10'h155) are inverted. h3_data_en and payload_en are both high in the H3 byte.
- R6: In the frame after a justification, the pointer word carries the new value sent plainly. After a positive justification the value is P+1, and after a negative one it is P-1, both taken modulo MAX_PTR: MAX_PTR-1 steps up to 0, and 0 steps down to MAX_PTR-1.
- R7: At least GUARD (3) normal frames separate any two justification frames, however strong the fill pressure. The first decision after reset is already permitted.
- R8: jcnt rises by exactly one at the start of each justification frame and changes at no other time.
- R9: The pointer word changes only at frame starts. Bits 15:12 are always 4'b0110, and bits 11:10 are always 0.
- R10: payload_en is high in every byte of column 3 and beyond, except a stuff byte. In overhead columns it is high only for the H3 byte of a negative justification frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock of the outgoing frame |
| rst_n | input | 1 | Active-low synchronous reset |
| fill | input | FILL_W | Current payload FIFO fill level |
| thr_lo | input | FILL_W | Fill level below which a positive justification is made |
| thr_hi | input | FILL_W | Fill level above which a negative justification is made |
| frame_start | output | 1 | First byte of a frame |
| h1_en | output | 1 | First pointer byte (high half of ptr_word) |
| h2_en | output | 1 | Second pointer byte (low half of ptr_word) |
| h3_en | output | 1 | Pointer action byte |
| h3_data_en | output | 1 | H3 carries a payload byte this frame |
| stuff_en | output | 1 | Byte after H3 is a stuff byte this frame |
| payload_en | output | 1 | Byte carries payload; read one byte from the FIFO |
| ptr_word | output | 16 | Pointer word announced in this frame |
| jcnt | output | JCNT_W | Wrapping count of justifications |

## Verification
The bench builds two copies with a 4-row by 5-column frame, so a frame lasts 20 clocks and every byte position of every frame can be compared against a computed map. Both copies use a 4-bit fill, which lets the bench sweep every fill value against the thresholds. The full 783-value pointer range is kept. One copy starts at 780 and the other at 1, so the up-wrap through 782→0 and the down-wrap through 0→782 each arrive within a handful of justifications. Runs of constant fill pressure show the guard spacing, and crossed thresholds show the priority rule.

// File: rtl/pjg_pkg.sv
`timescale 1ns/1ps
package pjg_pkg;
    typedef enum logic [1:0] {
        JUST_NONE = 2'd0,
        JUST_INC  = 2'd1,
        JUST_DEC  = 2'd2
    } just_e;

    localparam int          PTR_W      = 10;
    localparam int          WORD_W     = 16;
    localparam int          OH_COLS    = 3;
    localparam logic [3:0]  NDF_NORMAL = 4'b0110;
    localparam logic [9:0]  INC_MASK   = 10'h2AA;
    localparam logic [9:0]  DEC_MASK   = 10'h155;
endpackage

// File: rtl/pjg_frame_timer.sv
`timescale 1ns/1ps
module pjg_frame_timer #(
    parameter int ROWS    = 9,
    parameter int COLS    = 90,
    parameter int PTR_ROW = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_start,
    output logic frame_end,
    output logic at_h1,
    output logic at_h2,
    output logic at_h3,
    output logic in_oh,
    output logic at_stuff
);
    import pjg_pkg::*;

    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] PROW     = ROW_W'(PTR_ROW);
    localparam logic [COL_W-1:0] OH_C     = COL_W'(OH_COLS);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.col == LAST_COL) begin
            pos_d.col = '0;
            pos_d.row = (pos_q.row == LAST_ROW) ? '0 : pos_q.row + 1'b1;
        end else begin
            pos_d.col = pos_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign frame_start = (pos_q.row == '0) && (pos_q.col == '0);
    assign frame_end   = (pos_q.row == LAST_ROW) && (pos_q.col == LAST_COL);
    assign at_h1       = (pos_q.row == PROW) && (pos_q.col == COL_W'(0));
    assign at_h2       = (pos_q.row == PROW) && (pos_q.col == COL_W'(1));
    assign at_h3       = (pos_q.row == PROW) && (pos_q.col == COL_W'(2));
    assign in_oh       = (pos_q.col < OH_C);
    assign at_stuff    = (pos_q.row == PROW) && (pos_q.col == OH_C);
endmodule

// File: rtl/pjg_ptr_ctrl.sv
`timescale 1ns/1ps
module pjg_ptr_ctrl #(
    parameter int FILL_W   = 6,
    parameter int MAX_PTR  = 783,
    parameter int PTR_INIT = 0,
    parameter int JCNT_W   = 16,
    parameter int GUARD    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_end,
    input  logic [FILL_W-1:0]         fill,
    input  logic [FILL_W-1:0]         thr_lo,
    input  logic [FILL_W-1:0]         thr_hi,
    output logic [pjg_pkg::PTR_W-1:0] ptr,
    output pjg_pkg::just_e            just,
    output logic [JCNT_W-1:0]         jcnt
);
    import pjg_pkg::*;

    localparam int                GAP_W   = $clog2(GUARD + 1);
    localparam logic [GAP_W-1:0]  GAP_MAX = GAP_W'(GUARD);
    localparam logic [PTR_W-1:0]  PTR_TOP = PTR_W'(MAX_PTR - 1);
    localparam logic [PTR_W-1:0]  PTR_RST = PTR_W'(PTR_INIT);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        just_e             just;
        logic [GAP_W-1:0]  gap;
        logic [JCNT_W-1:0] jcnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [GAP_W-1:0] gap_next;

    always_comb begin
        st_d     = st_q;
        gap_next = st_q.gap;
        if (frame_end) begin
            unique case (st_q.just)
                JUST_INC: st_d.ptr = (st_q.ptr == PTR_TOP) ? '0 : st_q.ptr + 1'b1;
                JUST_DEC: st_d.ptr = (st_q.ptr == '0) ? PTR_TOP : st_q.ptr - 1'b1;
                default:  st_d.ptr = st_q.ptr;
            endcase
            if (st_q.just != JUST_NONE)  gap_next = '0;
            else if (st_q.gap >= GAP_MAX) gap_next = GAP_MAX;
            else                          gap_next = st_q.gap + 1'b1;
            st_d.gap  = gap_next;
            st_d.just = JUST_NONE;
            if (gap_next >= GAP_MAX) begin
                if (fill < thr_lo)      st_d.just = JUST_INC;
                else if (fill > thr_hi) st_d.just = JUST_DEC;
            end
            if (st_d.just != JUST_NONE) st_d.jcnt = st_q.jcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= PTR_RST;
            st_q.just <= JUST_NONE;
            st_q.gap  <= GAP_MAX;
            st_q.jcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign just = st_q.just;
    assign jcnt = st_q.jcnt;
endmodule

// File: rtl/pjg_word_fmt.sv
`timescale 1ns/1ps
module pjg_word_fmt (
    input  logic [pjg_pkg::PTR_W-1:0]  ptr,
    input  pjg_pkg::just_e             just,
    output logic [pjg_pkg::WORD_W-1:0] word
);
    import pjg_pkg::*;

    logic [PTR_W-1:0] flip;

    always_comb begin
        unique case (just)
            JUST_INC: flip = INC_MASK;
            JUST_DEC: flip = DEC_MASK;
            default:  flip = '0;
        endcase
    end

    assign word = {NDF_NORMAL, 2'b00, ptr ^ flip};
endmodule

// File: rtl/ptr_just_gen.sv
`timescale 1ns/1ps
module ptr_just_gen #(
    parameter int ROWS     = 9,
    parameter int COLS     = 90,
    parameter int PTR_ROW  = 3,
    parameter int FILL_W   = 6,
    parameter int MAX_PTR  = 783,
    parameter int PTR_INIT = 0,
    parameter int JCNT_W   = 16,
    parameter int GUARD    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] thr_lo,
    input  logic [FILL_W-1:0] thr_hi,
    output logic              frame_start,
    output logic              h1_en,
    output logic              h2_en,
    output logic              h3_en,
    output logic              h3_data_en,
    output logic              stuff_en,
    output logic              payload_en,
    output logic [15:0]       ptr_word,
    output logic [JCNT_W-1:0] jcnt
);
    import pjg_pkg::*;

    logic             frame_end;
    logic             in_oh;
    logic             at_stuff;
    logic [PTR_W-1:0] cur_ptr;
    just_e            cur_just;

    pjg_frame_timer #(
        .ROWS    (ROWS),
        .COLS    (COLS),
        .PTR_ROW (PTR_ROW)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .at_h1       (h1_en),
        .at_h2       (h2_en),
        .at_h3       (h3_en),
        .in_oh       (in_oh),
        .at_stuff    (at_stuff)
    );

    pjg_ptr_ctrl #(
        .FILL_W   (FILL_W),
        .MAX_PTR  (MAX_PTR),
        .PTR_INIT (PTR_INIT),
        .JCNT_W   (JCNT_W),
        .GUARD    (GUARD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .fill      (fill),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .ptr       (cur_ptr),
        .just      (cur_just),
        .jcnt      (jcnt)
    );

    pjg_word_fmt u_fmt (
        .ptr  (cur_ptr),
        .just (cur_just),
        .word (ptr_word)
    );

    assign stuff_en   = at_stuff && (cur_just == JUST_INC);
    assign h3_data_en = h3_en && (cur_just == JUST_DEC);
    assign payload_en = (!in_oh && !stuff_en) || h3_data_en;
endmodule

// File: rtl/pjg_checker.sv
`timescale 1ns/1ps
module pjg_checker #(
    parameter int JCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              h3_en,
    input logic              h3_data_en,
    input logic              stuff_en,
    input logic              payload_en,
    input logic [15:0]       ptr_word,
    input logic [JCNT_W-1:0] jcnt
);
    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                            since_q <= 3'd7;
        else if (stuff_en || h3_data_en)       since_q <= 3'd0;
        else if (frame_start && since_q != 3'd7) since_q <= since_q + 3'd1;
    end

    AST_STUFF_AFTER_H3: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_en |-> ($past(h3_en) && !payload_en)); // R4
    AST_H3_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        h3_data_en |-> (h3_en && payload_en)); // R5
    AST_JUST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_en || h3_data_en) |-> (since_q >= 3'd4)); // R7
    AST_JCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (jcnt != $past(jcnt)) |-> (frame_start && jcnt == JCNT_W'($past(jcnt) + 1'b1))); // R8
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(ptr_word)); // R9
    AST_WORD_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_word[15:10] == 6'b011000); // R9
endmodule

bind ptr_just_gen pjg_checker #(.JCNT_W(JCNT_W)) u_pjg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .h3_en       (h3_en),
    .h3_data_en  (h3_data_en),
    .stuff_en    (stuff_en),
    .payload_en  (payload_en),
    .ptr_word    (ptr_word),
    .jcnt        (jcnt)
);

// File: tb/ptr_just_gen_tb_top.sv
`timescale 1ns/1ps
module ptr_just_gen_tb_top;
    localparam int ROWS = 4;
    localparam int COLS = 5;
    localparam int PR   = 3;
    localparam int OH   = 3;
    localparam int FW   = 4;
    localparam int MAXP = 783;
    localparam int JW   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [FW-1:0] fill, lo, hi;

    logic          a_fs, a_h1, a_h2, a_h3, a_h3d, a_st, a_pay;
    logic [15:0]   a_word;
    logic [JW-1:0] a_jc;
    logic          b_fs, b_h1, b_h2, b_h3, b_h3d, b_st, b_pay;
    logic [15:0]   b_word;
    logic [JW-1:0] b_jc;

    ptr_just_gen #(.ROWS(ROWS), .COLS(COLS), .PTR_ROW(PR), .FILL_W(FW), .MAX_PTR(MAXP),
                   .PTR_INIT(780), .JCNT_W(JW), .GUARD(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .fill(fill), .thr_lo(lo), .thr_hi(hi),
        .frame_start(a_fs), .h1_en(a_h1), .h2_en(a_h2), .h3_en(a_h3),
        .h3_data_en(a_h3d), .stuff_en(a_st), .payload_en(a_pay),
        .ptr_word(a_word), .jcnt(a_jc));

    ptr_just_gen #(.ROWS(ROWS), .COLS(COLS), .PTR_ROW(PR), .FILL_W(FW), .MAX_PTR(MAXP),
                   .PTR_INIT(1), .JCNT_W(JW), .GUARD(3)) dut_w (
        .clk(clk), .rst_n(rst_n), .fill(fill), .thr_lo(lo), .thr_hi(hi),
        .frame_start(b_fs), .h1_en(b_h1), .h2_en(b_h2), .h3_en(b_h3),
        .h3_data_en(b_h3d), .stuff_en(b_st), .payload_en(b_pay),
        .ptr_word(b_word), .jcnt(b_jc));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int ptr_a = 780;
    int ptr_b = 1;
    int gap   = 3;
    int just  = 0;
    int jcnt_m = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int p, input int j);
        logic [9:0] m;
        m = (j == 1) ? 10'h2AA : (j == 2) ? 10'h155 : 10'h000;
        return {4'b0110, 2'b00, 10'(p) ^ m};
    endfunction

    task automatic run_frame(input int f, input string req);
        string jt;
        fill = FW'(f);
        jt = (just == 1) ? "R4" : (just == 2) ? "R5" : "R6";
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic fs, h1, h2, h3, st, h3d, pay;
                logic [6:0] ea;
                fs  = (r == 0) && (c == 0);
                h1  = (r == PR) && (c == 0);
                h2  = (r == PR) && (c == 1);
                h3  = (r == PR) && (c == 2);
                st  = (r == PR) && (c == OH) && (just == 1);
                h3d = h3 && (just == 2);
                pay = ((c >= OH) && !st) || h3d;
                ea  = {fs, h1, h2, h3, st, h3d, pay};
                // R2 R10 position strobes, R4 R5 justification strobes
                chk({a_fs, a_h1, a_h2, a_h3, a_st, a_h3d, a_pay} == ea,
                    (just == 0) ? "R2 R10" : jt, "strobes A", 32'({a_fs, a_h1, a_h2, a_h3, a_st, a_h3d, a_pay}), 32'(ea));
                chk({b_fs, b_h1, b_h2, b_h3, b_st, b_h3d, b_pay} == ea,
                    (just == 0) ? "R2 R10" : jt, "strobes B", 32'({b_fs, b_h1, b_h2, b_h3, b_st, b_h3d, b_pay}), 32'(ea));
                if (fs || h1) begin
                    chk(a_word == exp_word(ptr_a, just), {req, " ", jt, " R9"}, "word A", 32'(a_word), 32'(exp_word(ptr_a, just)));
                    chk(b_word == exp_word(ptr_b, just), {req, " ", jt, " R9"}, "word B", 32'(b_word), 32'(exp_word(ptr_b, just)));
                    chk(a_jc == JW'(jcnt_m), "R8", "jcnt A", 32'(a_jc), 32'(jcnt_m));
                    chk(b_jc == JW'(jcnt_m), "R8", "jcnt B", 32'(b_jc), 32'(jcnt_m));
                end
                @(negedge clk);
            end
        end
        // model update at frame boundary
        if (just == 1) begin
            ptr_a = (ptr_a + 1) % MAXP;
            ptr_b = (ptr_b + 1) % MAXP;
        end else if (just == 2) begin
            ptr_a = (ptr_a + MAXP - 1) % MAXP;
            ptr_b = (ptr_b + MAXP - 1) % MAXP;
        end
        gap  = (just != 0) ? 0 : ((gap >= 3) ? 3 : gap + 1);
        just = 0;
        if (gap >= 3) begin
            if (f < int'(lo))      just = 1;
            else if (f > int'(hi)) just = 2;
        end
        if (just != 0) jcnt_m++;
    endtask

    initial begin
        rst_n = 1'b0;
        fill  = 4'd7;
        lo    = 4'd4;
        hi    = 4'd11;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(a_word == 16'h6000 + 16'd780, "R1", "reset word A", 32'(a_word), 32'h6000 + 32'd780);
        chk(b_word == 16'h6001, "R1", "reset word B", 32'(b_word), 32'h6001);
        chk(a_jc == '0 && b_jc == '0, "R1", "reset jcnt", 32'({a_jc, b_jc}), 32'd0);
        chk(!a_st && !a_h3d && !b_st && !b_h3d, "R1", "reset strobes", 32'({a_st, a_h3d, b_st, b_h3d}), 32'd0);
        rst_n = 1'b1;
        run_frame(7, "R1");
        // R3 sweep over all fill values, each followed by neutral frames (R6)
        for (int f = 0; f < 16; f++) begin
            run_frame(f, "R3");
            for (int k = 0; k < 4; k++) run_frame(7, "R6");
        end
        // R7 sustained pressure: spacing and down-wrap of copy B
        for (int k = 0; k < 12; k++) run_frame(15, "R7");
        for (int k = 0; k < 12; k++) run_frame(0, "R7");
        for (int k = 0; k < 4; k++) run_frame(7, "R6");
        // R3 crossed thresholds: positive wins
        lo = 4'd10;
        hi = 4'd5;
        for (int k = 0; k < 5; k++) run_frame(7, "R3");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run not finished, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule